// File: doc/BRIEF.md
# DMA Channel Request Capture

This block holds the request side of one DMA channel. It picks one request line out of a bank of source lines, using a mode bit together with a 4-bit select field. It resynchronises the bank into the local clock and turns each rising edge of the chosen line into a request event. The event sets a pending flag that software can read. Two channels are built by placing two copies side by side. The address counters and the transfer engine sit outside this block.

The flag is set on every request event, whether or not the channel is enabled. Software may clear the flag with a bus write but can never set it. When the channel is enabled, a pending flag raises a transfer-start pulse to the engine, and the flag drops on the clock edge where the engine acknowledges. So on an enabled channel software almost always reads the flag as 0. Changing the mode or the select field can look like a rising edge on the newly chosen line, which sets the flag by mistake. For that reason software clears the flag after every change of selection.

Top module: `dma_req_capture`

## Requirements
- R1: After reset the pending flag, the mode bit, the select field and the transfer-start output are all 0.
- R2: The selected source is line `src_i[{mode, sel}]`, with the mode bit as the index MSB, so mode 1 picks lines 16 to 31. A rising edge on any other line leaves the flag unchanged.
- R3: A rising edge of the selected line, applied between two clock edges, is visible on `pend_o` after the third following clock edge and not after the second. A falling edge does not set the flag.
- R4: A request event sets the flag whether `chan_en` is 0 or 1. While `chan_en` is 0 the flag stays set until software clears it.
- R5: `xfer_start` is 1 exactly when the flag is set and `chan_en` is 1.
- R6: A clock edge with `xfer_start` and `xfer_ack` both high clears the flag. `xfer_ack` while `xfer_start` is low has no effect.
- R7: A flag write with data 0 clears the flag. A flag write with data 1 leaves the flag unchanged, so a clear flag stays 0.
- R8: Suppose a selection write moves from a line whose synchronised level is 0 to one whose level is 1. The flag is then set on the clock edge after the write edge. Moving between two lines that are both 1 sets nothing.
- R9: If a request event and a software clear fall on the same clock edge, the flag ends set.
- R10: A selection write updates `mode_o` and `sel_o` at the write clock edge. A flag write leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Request source lines, asynchronous |
| sel_we | input | 1 | Write strobe for the mode and select fields |
| mode_wdata | input | 1 | Mode bit write data |
| sel_wdata | input | 4 | Select field write data |
| flag_we | input | 1 | Write strobe for the pending flag |
| flag_wdata | input | 1 | Flag write data: 0 clears, 1 is ignored |
| chan_en | input | 1 | Channel enable |
| xfer_ack | input | 1 | Transfer engine acknowledge |
| xfer_start | output | 1 | Request to the transfer engine |
| pend_o | output | 1 | Pending flag readback |
| mode_o | output | 1 | Mode bit readback |
| sel_o | output | 4 | Select field readback |

## Verification
A wrong selection index, or a bad previous-level register, shows up as a flag that sets on the wrong line or stays clear. This is visible on `pend_o` three cycles after the source edge, so a sweep of every select value against every source line exposes it. A wrong priority between set and clear shows on the very next clock edge, in the flag readback or in `xfer_start`. The spurious set caused by reselection is checked exactly one cycle after the write, and its absence is checked when the old and new lines are both high.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
   typedef enum logic [1:0] {
      FLG_HOLD   = 2'd0,
      FLG_SET    = 2'd1,
      FLG_HW_CLR = 2'd2,
      FLG_SW_CLR = 2'd3
   } flg_act_e;

   function automatic flg_act_e pick_act(input logic evt, input logic hw_clr,
                                         input logic sw_clr);
      if (evt)         return FLG_SET;
      else if (hw_clr) return FLG_HW_CLR;
      else if (sw_clr) return FLG_SW_CLR;
      else             return FLG_HOLD;
   endfunction
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dreq_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("dreq_sync: W must be positive");
   end

   logic [W-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dreq_src_sel.sv
module dreq_src_sel #(
   parameter int MODE_W = 1,
   parameter int SEL_W  = 4,
   localparam int IDX_W = MODE_W + SEL_W,
   localparam int N_SRC = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_sync_i,
   input  logic              sel_we,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic [SEL_W-1:0]  sel_wdata,
   output logic [MODE_W-1:0] mode_o,
   output logic [SEL_W-1:0]  sel_o,
   output logic              evt_o
);
   if (MODE_W < 1 || SEL_W < 1) begin : g_bad_w
      $error("dreq_src_sel: field widths must be positive");
   end

   logic [MODE_W-1:0] mode_q;
   logic [SEL_W-1:0]  sel_q;
   logic [IDX_W-1:0]  idx;
   logic              line_lvl;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         sel_q  <= '0;
      end else if (sel_we) begin
         mode_q <= mode_wdata;
         sel_q  <= sel_wdata;
      end
   end

   assign idx      = {mode_q, sel_q};
   assign line_lvl = src_sync_i[idx];

   // previous level of whatever line is selected now; a reselection
   // compares the new line against the old line's level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= line_lvl;
   end

   assign evt_o  = line_lvl & ~prev_q;
   assign mode_o = mode_q;
   assign sel_o  = sel_q;

   // R10
   sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_we |=> (mode_o == $past(mode_wdata) && sel_o == $past(sel_wdata)));
   // R10
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_we |=> ($stable(mode_o) && $stable(sel_o)));
endmodule

// File: rtl/dreq_flag.sv
module dreq_flag
   import dreq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic flag_we,
   input  logic flag_wdata,
   input  logic chan_en,
   input  logic xfer_ack,
   output logic xfer_start,
   output logic pend_o
);
   logic     pend_q;
   logic     hw_clr;
   logic     sw_clr;
   flg_act_e act;

   assign xfer_start = pend_q & chan_en;
   assign hw_clr     = xfer_start & xfer_ack;
   assign sw_clr     = flag_we & ~flag_wdata;
   assign act        = pick_act(evt_i, hw_clr, sw_clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else begin
         case (act)
            FLG_SET:                pend_q <= 1'b1;
            FLG_HW_CLR, FLG_SW_CLR: pend_q <= 1'b0;
            default:                pend_q <= pend_q;
         endcase
      end
   end

   assign pend_o = pend_q;

   // R4
   evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> pend_o);
   // R7
   no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_o && !evt_i) |=> !pend_o);
   // R6
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_start && xfer_ack && !evt_i) |=> !pend_o);
   // R4
   disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && !chan_en && !(flag_we && !flag_wdata)) |=> pend_o);
endmodule

// File: rtl/dma_req_capture.sv
module dma_req_capture #(
   parameter int MODE_W      = 1,
   parameter int SEL_W       = 4,
   parameter int SYNC_STAGES = 2,
   localparam int N_SRC      = 1 << (MODE_W + SEL_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_i,
   input  logic              sel_we,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic [SEL_W-1:0]  sel_wdata,
   input  logic              flag_we,
   input  logic              flag_wdata,
   input  logic              chan_en,
   input  logic              xfer_ack,
   output logic              xfer_start,
   output logic              pend_o,
   output logic [MODE_W-1:0] mode_o,
   output logic [SEL_W-1:0]  sel_o
);
   if (N_SRC > 1024) begin : g_bad_size
      $error("dma_req_capture: source bank too wide");
   end

   logic [N_SRC-1:0] src_sync;
   logic             evt;

   dreq_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (src_i),
      .q_o   (src_sync)
   );

   dreq_src_sel #(.MODE_W(MODE_W), .SEL_W(SEL_W)) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_sync_i (src_sync),
      .sel_we     (sel_we),
      .mode_wdata (mode_wdata),
      .sel_wdata  (sel_wdata),
      .mode_o     (mode_o),
      .sel_o      (sel_o),
      .evt_o      (evt)
   );

   dreq_flag u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt),
      .flag_we    (flag_we),
      .flag_wdata (flag_wdata),
      .chan_en    (chan_en),
      .xfer_ack   (xfer_ack),
      .xfer_start (xfer_start),
      .pend_o     (pend_o)
   );
endmodule

// File: tb/dma_req_capture_tb.sv
`timescale 1ns/1ps
module dma_req_capture_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_i = '0;
   logic        sel_we = 1'b0, mode_wdata = 1'b0, flag_we = 1'b0, flag_wdata = 1'b0;
   logic [3:0]  sel_wdata = '0;
   logic        chan_en = 1'b0, xfer_ack = 1'b0;
   logic        xfer_start, pend_o, mode_o;
   logic [3:0]  sel_o;
   int          checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   dma_req_capture u_dut (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .sel_we(sel_we),
      .mode_wdata(mode_wdata), .sel_wdata(sel_wdata), .flag_we(flag_we),
      .flag_wdata(flag_wdata), .chan_en(chan_en), .xfer_ack(xfer_ack),
      .xfer_start(xfer_start), .pend_o(pend_o), .mode_o(mode_o), .sel_o(sel_o)
   );

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_sel(logic [4:0] idx);
      sel_we = 1'b1; mode_wdata = idx[4]; sel_wdata = idx[3:0];
      tick();
      sel_we = 1'b0;
   endtask

   task automatic wr_flag(logic d);
      flag_we = 1'b1; flag_wdata = d;
      tick();
      flag_we = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      tick(3);
      // R1 reset state
      check("R1 pend", pend_o, 0);
      check("R1 mode/sel", {mode_o, sel_o}, 0);
      check("R1 start", xfer_start, 0);
      rst_n = 1'b1;
      tick(2);

      // R2 sweep every selection against every source line
      for (int idx = 0; idx < 32; idx++) begin
         wr_sel(idx[4:0]);
         // R10 readback
         check("R10 readback", {mode_o, sel_o}, idx);
         wr_flag(1'b0);
         for (int j = 0; j < 32; j++) begin
            src_i[j] = 1'b1;
            tick(3);
            check("R2 select", pend_o, (j == idx) ? 1 : 0);
            src_i[j] = 1'b0;
            tick(3);
            wr_flag(1'b0);
         end
      end

      // R3 latency and falling edge
      wr_sel(5'd5);
      wr_flag(1'b0);
      src_i[5] = 1'b1;
      tick(2);
      check("R3 not yet", pend_o, 0);
      tick();
      check("R3 set", pend_o, 1);
      wr_flag(1'b0);
      src_i[5] = 1'b0;
      tick(4);
      check("R3 falling", pend_o, 0);

      // R4 set while disabled, held
      chan_en = 1'b0;
      src_i[5] = 1'b1;
      tick(3);
      tick(5);
      check("R4 held", pend_o, 1);
      check("R5 start off when disabled", xfer_start, 0);
      // R6 ack without start ignored
      xfer_ack = 1'b1;
      tick();
      xfer_ack = 1'b0;
      check("R6 ack ignored", pend_o, 1);
      // R7 write 1 ignored, write 0 clears
      wr_flag(1'b1);
      check("R7 write1", pend_o, 1);
      wr_flag(1'b0);
      check("R7 clear", pend_o, 0);
      wr_flag(1'b1);
      check("R7 no set", pend_o, 0);
      src_i[5] = 1'b0;
      tick(3);

      // R4 enabled: start raised, R6 ack clears
      chan_en = 1'b1;
      src_i[5] = 1'b1;
      tick(3);
      check("R4 set enabled", pend_o, 1);
      check("R5 start", xfer_start, 1);
      xfer_ack = 1'b1;
      tick();
      xfer_ack = 1'b0;
      check("R6 cleared", pend_o, 0);
      check("R5 start low", xfer_start, 0);
      chan_en = 1'b0;
      src_i[5] = 1'b0;
      tick(3);

      // R9 set beats clear on the same edge
      src_i[5] = 1'b1;
      tick(2);
      flag_we = 1'b1; flag_wdata = 1'b0;
      tick();
      flag_we = 1'b0;
      check("R9 set wins", pend_o, 1);
      wr_flag(1'b0);
      check("R9 later clear", pend_o, 0);
      src_i[5] = 1'b0;

      // R8 reselection to a high line
      wr_sel(5'd0);
      src_i[7] = 1'b1;
      tick(4);
      wr_flag(1'b0);
      wr_sel(5'd7);
      check("R8 write edge", pend_o, 0);
      tick();
      check("R8 spurious set", pend_o, 1);
      wr_flag(1'b0);
      src_i[23] = 1'b1;
      tick(4);
      wr_sel(5'd23);
      tick(2);
      check("R8 high to high", pend_o, 0);
      // R10 flag write leaves selection
      wr_flag(1'b0);
      check("R10 unchanged", {mode_o, sel_o}, 23);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule